// File: doc/BRIEF.md
# Snooping Byte Sequencer for a One- or Two-Bus Flash Master

This block drives the byte-level traffic of a serial flash master that can hang one or two flash devices on separate busses. Software fills a transmit FIFO and fires a one-cycle start pulse. The sequencer then keeps moving bytes until the transmit FIFO runs dry. For each step it takes a byte, hands it to a per-bus byte exchanger, waits for the exchanged byte to come back, and writes the result to a receive FIFO. Bit shifting and the FIFOs themselves sit outside this block.

The first byte sent after the chip selects go idle is treated as a command and inspected. Certain read commands start a short countdown covering the address, mode and dummy bytes that follow. When the countdown runs out, the block stops sending each byte identically on every bus. From then on it stripes data: each bus takes its own byte from the transmit FIFO and returns its own byte to the receive FIFO. Underflow and overflow are reported as one-cycle pulses.

Top module: `spi_stripe_seq`

## Requirements
- R1: After reset, busy_o, tx_pop_o, rx_push_o, bus_req_o and both flag pulses are low, and the snoop state is "checking". A start_i pulse while idle begins a run. A start_i pulse during a run is ignored and does not cause a second run.
- R2: When a step needs a byte and tx_empty_i is high, underflow_o pulses for one cycle and the run ends. busy_o is low the next cycle. Every run therefore ends with exactly one underflow pulse, even in the middle of a striped step.
- R3: When a received byte is ready and rx_full_i is high, the byte is not pushed and overflow_o pulses for one cycle. The run carries on with the next byte.
- R4: Two busses are used only when cfg_sep_bus_i and cfg_two_mem_i are both 1 and NUM_BUS is at least 2. Otherwise only bus 0 is requested, even while striping.
- R5: A step that is not striped pops one byte and sends that same byte on every active bus. Only the byte returned by bus 0 is pushed, in transfer order.
- R6: While the snoop state is "checking", the byte sent is compared against the read commands. Opcodes 0x0B, 0x6B and 0xBB load a countdown of 4. Opcode 0xEB loads 6. Any other byte selects "none", which never stripes.
- R7: Each unstriped step while counting lowers the count by one. The step that brings the count to zero enters striping. Exactly N mirrored steps therefore follow a command that loads N.
- R8: In a striped step, each active bus in turn pops its own byte and pushes its own returned byte, starting with bus 0. Striping persists across runs.
- R9: A cycle with cs_idle_i high returns the snoop state to "checking" on the next cycle. Without it, the snoop state is kept from one run to the next.
- R10: A bus request stays high until that bus returns bus_ack_i. The returned byte bus_rxd_i is captured on the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a run |
| cfg_sep_bus_i | input | 1 | Configuration: separate busses |
| cfg_two_mem_i | input | 1 | Configuration: two memories fitted |
| cs_idle_i | input | 1 | No chip select is active |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | BYTE_W | Head byte of the transmit FIFO (shown ahead of the pop) |
| tx_pop_o | output | 1 | Remove the head byte of the transmit FIFO |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Write rx_data_o into the receive FIFO |
| rx_data_o | output | BYTE_W | Byte for the receive FIFO |
| bus_req_o | output | NUM_BUS | Per-bus request to exchange a byte |
| bus_txd_o | output | NUM_BUS*BYTE_W | Per-bus byte to send, bus b at bits b*BYTE_W upward |
| bus_ack_i | input | NUM_BUS | Per-bus one-cycle exchange completion |
| bus_rxd_i | input | NUM_BUS*BYTE_W | Per-bus returned byte, valid with bus_ack_i |
| underflow_o | output | 1 | Pulse: a byte was needed from an empty transmit FIFO |
| overflow_o | output | 1 | Pulse: a returned byte was dropped because the receive FIFO was full |
| busy_o | output | 1 | A run is in progress |

## Verification
Several rules are checked on every cycle by the assertions:
- quiet outputs while idle;
- pops only from a non-empty FIFO and pushes only into a non-full one;
- overflow pulses only when the receive FIFO is full and nothing is pushed;
- the end of the run after underflow;
- request holding until acknowledge;
- the return to "checking" after chip-select idle.

Other behaviour needs whole-run scenarios. The opcode-dependent countdown length, the switch from mirrored to striped byte order and the bus-0-first order inside a striped step can only be shown there. So can the single-bus fallback and the persistence of the snoop state between runs. The scoreboard predicts every pushed byte and every per-bus byte for these scenarios.

// File: rtl/spi_stripe_pkg.sv
// Shared types for the snooping byte sequencer.
// Assumes byte-wide commands; the countdown fits in SNOOP_CNT_W bits.
package spi_stripe_pkg;

    localparam int SNOOP_CNT_W = 3;

    typedef enum logic [1:0] {
        SNP_CHECK,   // next byte sent is inspected as a command
        SNP_NONE,    // command seen, never stripes
        SNP_COUNT,   // counting down mirrored bytes
        SNP_STRIPE   // per-bus independent bytes
    } snoop_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_COMMIT
    } seq_state_e;

    // Countdown loaded by a command byte; zero means "not a striping read"
    function automatic logic [SNOOP_CNT_W-1:0] cmd_countdown(input logic [7:0] op);
        case (op)
            8'h0B, 8'h6B, 8'hBB: cmd_countdown = SNOOP_CNT_W'(4);
            8'hEB:               cmd_countdown = SNOOP_CNT_W'(6);
            default:             cmd_countdown = '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_snoop_track.sv
// Command snoop tracker: inspects the first byte after chip-select idle
// and counts down the mirrored bytes before striping is entered.
// Assumes step_i pulses once per completed unstriped step with byte_i valid.
module spi_snoop_track
    import spi_stripe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_idle_i,
    input  logic        step_i,
    input  logic [7:0]  byte_i,
    output snoop_mode_e mode_o,
    output logic        stripe_o
);

    logic [SNOOP_CNT_W-1:0] cnt_q;
    logic [SNOOP_CNT_W-1:0] load_cnt;

    // Countdown value for the byte just sent
    always_comb load_cnt = cmd_countdown(byte_i);

    // Snoop state register; chip-select idle has priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= SNP_CHECK;
            cnt_q  <= '0;
        end else if (cs_idle_i) begin
            mode_o <= SNP_CHECK;
            cnt_q  <= '0;
        end else if (step_i) begin
            case (mode_o)
                SNP_CHECK: begin
                    if (load_cnt != '0) begin
                        mode_o <= SNP_COUNT;
                        cnt_q  <= load_cnt;
                    end else begin
                        mode_o <= SNP_NONE;
                    end
                end
                SNP_COUNT: begin
                    if (cnt_q == SNOOP_CNT_W'(1)) begin
                        mode_o <= SNP_STRIPE;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q - SNOOP_CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Striping indication for the sequencer
    always_comb stripe_o = (mode_o == SNP_STRIPE);

endmodule

// File: rtl/spi_bus_lane.sv
// One bus lane: holds a request with its byte until the bus acknowledges,
// then keeps the returned byte and a done flag until cleared.
// Assumes launch_i and clear_i never coincide with a pending request.
module spi_bus_lane #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              clear_i,
    input  logic [BYTE_W-1:0] txd_i,
    input  logic              ack_i,
    input  logic [BYTE_W-1:0] rxd_i,
    output logic              req_o,
    output logic [BYTE_W-1:0] txd_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rxd_o
);

    // Request and done handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            if (launch_i)           req_o <= 1'b1;
            else if (ack_i && req_o) req_o <= 1'b0;
            if (clear_i)            done_o <= 1'b0;
            else if (ack_i && req_o) done_o <= 1'b1;
        end
    end

    // Outgoing byte latched at launch, returned byte latched at acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_o <= '0;
            rxd_o <= '0;
        end else begin
            if (launch_i)            txd_o <= txd_i;
            if (ack_i && req_o)      rxd_o <= rxd_i;
        end
    end

endmodule

// File: rtl/spi_stripe_seq.sv
// Byte sequencer for a one- or two-bus flash master. Moves bytes from the
// transmit FIFO through the bus lanes into the receive FIFO until the
// transmit FIFO is empty, mirroring or striping as the snoop state dictates.
// Assumes a first-word-fall-through transmit FIFO and configuration inputs
// that are stable while busy_o is high.
module spi_stripe_seq
    import spi_stripe_pkg::*;
#(
    parameter int NUM_BUS = 2,
    parameter int BYTE_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      cfg_sep_bus_i,
    input  logic                      cfg_two_mem_i,
    input  logic                      cs_idle_i,
    input  logic                      tx_empty_i,
    input  logic [BYTE_W-1:0]         tx_data_i,
    output logic                      tx_pop_o,
    input  logic                      rx_full_i,
    output logic                      rx_push_o,
    output logic [BYTE_W-1:0]         rx_data_o,
    output logic [NUM_BUS-1:0]        bus_req_o,
    output logic [NUM_BUS*BYTE_W-1:0] bus_txd_o,
    input  logic [NUM_BUS-1:0]        bus_ack_i,
    input  logic [NUM_BUS*BYTE_W-1:0] bus_rxd_i,
    output logic                      underflow_o,
    output logic                      overflow_o,
    output logic                      busy_o
);

    localparam int IDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
    localparam logic [NUM_BUS-1:0] ALL_LANES = '1;
    localparam logic [NUM_BUS-1:0] LANE0     = NUM_BUS'(1);

    seq_state_e         state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   last_idx;
    logic               multi_q;
    logic               stripe_q;
    logic               stripe_now;
    logic               fetch_ok;
    logic               commit;
    logic               all_done;
    logic [NUM_BUS-1:0] launch_mask;
    logic [NUM_BUS-1:0] wait_mask_q;
    logic [NUM_BUS-1:0] lane_done;
    logic [BYTE_W-1:0]  lane_rx [NUM_BUS];
    snoop_mode_e        snoop_mode;
    logic               snoop_stripe;

    // Step decode: stripe choice is taken from the snoop at bus 0 and held for the step
    always_comb begin
        stripe_now = (idx_q == '0) ? snoop_stripe : stripe_q;
        fetch_ok   = (state_q == ST_FETCH) && !tx_empty_i;
        commit     = (state_q == ST_COMMIT);
        last_idx   = multi_q ? IDX_W'(NUM_BUS - 1) : '0;
        all_done   = &(lane_done | ~wait_mask_q);
        if (!fetch_ok)       launch_mask = '0;
        else if (stripe_now) launch_mask = LANE0 << idx_q;
        else if (multi_q)    launch_mask = ALL_LANES;
        else                 launch_mask = LANE0;
    end

    // Run control: fetch, wait for the lanes, commit, repeat until empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            multi_q     <= 1'b0;
            stripe_q    <= 1'b0;
            wait_mask_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        multi_q <= (NUM_BUS > 1) && cfg_sep_bus_i && cfg_two_mem_i;
                        idx_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (tx_empty_i) begin
                        idx_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        stripe_q    <= stripe_now;
                        wait_mask_q <= launch_mask;
                        state_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (all_done) state_q <= ST_COMMIT;
                end
                default: begin
                    if (stripe_q && (idx_q != last_idx)) idx_q <= idx_q + IDX_W'(1);
                    else                                idx_q <= '0;
                    state_q <= ST_FETCH;
                end
            endcase
        end
    end

    // One lane per bus
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
        spi_bus_lane #(.BYTE_W(BYTE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .launch_i (launch_mask[g]),
            .clear_i  (commit),
            .txd_i    (tx_data_i),
            .ack_i    (bus_ack_i[g]),
            .rxd_i    (bus_rxd_i[g*BYTE_W +: BYTE_W]),
            .req_o    (bus_req_o[g]),
            .txd_o    (bus_txd_o[g*BYTE_W +: BYTE_W]),
            .done_o   (lane_done[g]),
            .rxd_o    (lane_rx[g])
        );
    end

    // Command snoop, stepped once per completed unstriped step
    spi_snoop_track u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_idle_i (cs_idle_i),
        .step_i    (commit && !stripe_q),
        .byte_i    (bus_txd_o[7:0]),
        .mode_o    (snoop_mode),
        .stripe_o  (snoop_stripe)
    );

    // FIFO-side strobes and flags
    always_comb begin
        tx_pop_o    = fetch_ok;
        rx_data_o   = stripe_q ? lane_rx[idx_q] : lane_rx[0];
        rx_push_o   = commit && !rx_full_i;
        overflow_o  = commit && rx_full_i;
        underflow_o = (state_q == ST_FETCH) && tx_empty_i;
        busy_o      = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/spi_stripe_seq_chk.sv
// Cycle-level checker for the snooping byte sequencer, bound to the top.
module spi_stripe_seq_chk
    import spi_stripe_pkg::*;
#(
    parameter int NUM_BUS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_idle_i,
    input logic               tx_empty_i,
    input logic               tx_pop_o,
    input logic               rx_full_i,
    input logic               rx_push_o,
    input logic               overflow_o,
    input logic               underflow_o,
    input logic               busy_o,
    input logic [NUM_BUS-1:0] bus_req_o,
    input logic [NUM_BUS-1:0] bus_ack_i,
    input snoop_mode_e        mode_i
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (bus_req_o == '0 && !tx_pop_o && !rx_push_o)); // R1

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> !tx_empty_i); // R2

    AST_UNDERFLOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> !busy_o); // R2

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |-> !rx_full_i); // R3

    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (rx_full_i && !rx_push_o)); // R3

    AST_CS_TO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle_i |=> (mode_i == SNP_CHECK)); // R9

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_req
        AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_req_o[b] && !bus_ack_i[b]) |=> bus_req_o[b]); // R10
    end

endmodule

bind spi_stripe_seq spi_stripe_seq_chk #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_idle_i   (cs_idle_i),
    .tx_empty_i  (tx_empty_i),
    .tx_pop_o    (tx_pop_o),
    .rx_full_i   (rx_full_i),
    .rx_push_o   (rx_push_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o),
    .busy_o      (busy_o),
    .bus_req_o   (bus_req_o),
    .bus_ack_i   (bus_ack_i),
    .mode_i      (snoop_mode)
);

// File: tb/spi_stripe_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: run tasks predict every bus byte and every pushed byte,
// a monitor process compares them as the design produces them.
module spi_stripe_seq_bench;

    localparam int NB = 2;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cfg_sep_bus_i = 1'b0;
    logic          cfg_two_mem_i = 1'b0;
    logic          cs_idle_i = 1'b0;
    logic          tx_empty_i = 1'b1;
    logic [BW-1:0] tx_data_i = '0;
    logic          tx_pop_o;
    logic          rx_full_i = 1'b0;
    logic          rx_push_o;
    logic [BW-1:0] rx_data_o;
    logic [NB-1:0] bus_req_o;
    logic [NB*BW-1:0] bus_txd_o;
    logic [NB-1:0] bus_ack_i = '0;
    logic [NB*BW-1:0] bus_rxd_i = '0;
    logic          underflow_o;
    logic          overflow_o;
    logic          busy_o;

    spi_stripe_seq #(.NUM_BUS(NB), .BYTE_W(BW)) u_spi_stripe_seq (.*);

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;

    logic [7:0] txq [$];
    logic [7:0] exp_rx [$];
    logic [7:0] exp_bus0 [$];
    logic [7:0] exp_bus1 [$];
    int rx_occ = 0;
    int rx_cap = 64;
    int exp_ovf = 0, seen_ovf = 0;
    int exp_unf = 0, seen_unf = 0;
    int sn_mode = 0;   // 0 checking, 1 none, 2 counting, 3 striping
    int sn_cnt = 0;
    logic [NB-1:0] req_prev = '0;

    function automatic logic [7:0] bus_key(input int b);
        return 8'hA5 ^ 8'(b * 8'h3C);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor and bus/FIFO models: sample away from the edge, drive after it
    initial begin
        logic pop_s;
        logic [NB-1:0] req_s;
        logic [NB*BW-1:0] txd_s;
        forever begin
            @(negedge clk);
            pop_s = tx_pop_o;
            req_s = bus_req_o;
            txd_s = bus_txd_o;
            if (rx_push_o) begin
                rx_occ++;
                if (exp_rx.size() == 0) check(1'b0, "R5 unexpected push", rx_data_o, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    check(rx_data_o == e, "R5/R8 rx byte", rx_data_o, e);
                end
            end
            if (overflow_o) seen_ovf++;
            if (underflow_o) seen_unf++;
            if (req_s[0] && !req_prev[0]) begin
                if (exp_bus0.size() == 0) check(1'b0, "R4 unexpected bus0 request", txd_s[7:0], 0);
                else begin
                    logic [7:0] e;
                    e = exp_bus0.pop_front();
                    check(txd_s[7:0] == e, "R10 bus0 byte", txd_s[7:0], e);
                end
            end
            if (req_s[1] && !req_prev[1]) begin
                if (exp_bus1.size() == 0) check(1'b0, "R4 unexpected bus1 request", txd_s[15:8], 0);
                else begin
                    logic [7:0] e;
                    e = exp_bus1.pop_front();
                    check(txd_s[15:8] == e, "R10 bus1 byte", txd_s[15:8], e);
                end
            end
            req_prev = req_s;
            @(posedge clk);
            #1;
            if (pop_s && txq.size() > 0) void'(txq.pop_front());
            for (int b = 0; b < NB; b++) begin
                bus_ack_i[b] = req_s[b] && !bus_ack_i[b];
                bus_rxd_i[b*BW +: BW] = txd_s[b*BW +: BW] ^ bus_key(b);
            end
            tx_empty_i = (txq.size() == 0);
            tx_data_i  = (txq.size() > 0) ? txq[0] : 8'h00;
            rx_full_i  = (rx_occ >= rx_cap);
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic expect_rx(input logic [7:0] v, inout int occ);
        if (occ >= rx_cap) exp_ovf++;
        else begin
            exp_rx.push_back(v);
            occ++;
        end
    endtask

    // Reference model of one run (R2-R8)
    task automatic predict(input logic [7:0] data [$], input bit two);
        int i = 0;
        int occ = rx_occ;
        int nb = two ? 2 : 1;
        exp_unf++;
        forever begin
            if (sn_mode == 3) begin
                for (int b = 0; b < nb; b++) begin
                    if (i == data.size()) return;
                    if (b == 0) exp_bus0.push_back(data[i]); else exp_bus1.push_back(data[i]);
                    expect_rx(data[i] ^ bus_key(b), occ);
                    i++;
                end
            end else begin
                logic [7:0] v;
                if (i == data.size()) return;
                v = data[i];
                i++;
                exp_bus0.push_back(v);
                if (two) exp_bus1.push_back(v);
                expect_rx(v ^ bus_key(0), occ);
                if (sn_mode == 0) begin
                    if (v == 8'h0B || v == 8'h6B || v == 8'hBB) begin sn_mode = 2; sn_cnt = 4; end
                    else if (v == 8'hEB) begin sn_mode = 2; sn_cnt = 6; end
                    else sn_mode = 1;
                end else if (sn_mode == 2) begin
                    sn_cnt--;
                    if (sn_cnt == 0) sn_mode = 3;
                end
            end
        end
    endtask

    // Driver: load the FIFO, predict, start, wait, then compare the totals
    task automatic run(input string tag, input logic [7:0] data [$],
                       input bit sep, input bit two, input bit restart);
        int guard = 0;
        cfg_sep_bus_i = sep;
        cfg_two_mem_i = two;
        foreach (data[k]) txq.push_back(data[k]);
        predict(data, sep && two);
        repeat (2) @(posedge clk);
        #1 start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        if (restart) begin
            repeat (3) @(posedge clk);
            #1 start_i = 1'b1;
            @(posedge clk);
            #1 start_i = 1'b0;
        end
        @(negedge clk);
        while (busy_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(exp_rx.size() == 0, {tag, " R5/R8 pending rx"}, exp_rx.size(), 0);
        check(exp_bus0.size() == 0 && exp_bus1.size() == 0, {tag, " R4 pending bus bytes"},
              exp_bus0.size() + exp_bus1.size(), 0);
        check(seen_unf == exp_unf, {tag, " R2 underflow pulses"}, seen_unf, exp_unf);
        check(seen_ovf == exp_ovf, {tag, " R3 overflow pulses"}, seen_ovf, exp_ovf);
        check(txq.size() == 0, {tag, " R1 tx fifo drained"}, txq.size(), 0);
    endtask

    task automatic chip_idle();
        @(posedge clk);
        #1 cs_idle_i = 1'b1;
        @(posedge clk);
        #1 cs_idle_i = 1'b0;
        sn_mode = 0;
        sn_cnt = 0;
    endtask

    task automatic drain_rx();
        @(posedge clk);
        #1 rx_occ = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !tx_pop_o && !rx_push_o && bus_req_o == '0 &&
              !underflow_o && !overflow_o, "R1 reset outputs", {busy_o, bus_req_o}, 0);

        // R4: one bus only when two-memory bit is clear; command 0xEB still counted
        run("single", '{8'hEB, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09},
            1'b1, 1'b0, 1'b0);
        chip_idle();

        // R6/R7/R8: 0x6B loads 4, then striping; a restart pulse during the run is ignored (R1)
        run("quad6b", '{8'h6B, 8'hA1, 8'hA2, 8'hA3, 8'hD0, 8'h10, 8'h11, 8'h12, 8'h13},
            1'b1, 1'b1, 1'b1);
        drain_rx();

        // R8/R9/R2: striping persists, odd byte count underflows mid-step
        run("persist", '{8'h21, 8'h22, 8'h23}, 1'b1, 1'b1, 1'b0);
        drain_rx();

        // R9/R6: after chip idle, a non-read command never stripes (R5 mirrored)
        chip_idle();
        run("none", '{8'h03, 8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45}, 1'b1, 1'b1, 1'b0);
        drain_rx();

        // R6/R7: 0xEB loads 6 mirrored steps
        chip_idle();
        run("quadeb", '{8'hEB, 8'h50, 8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h60, 8'h61, 8'h62, 8'h63},
            1'b1, 1'b1, 1'b0);
        drain_rx();

        // R6/R7: 0xBB and 0x0B load 4
        chip_idle();
        run("dualbb", '{8'hBB, 8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75}, 1'b1, 1'b1, 1'b0);
        drain_rx();
        chip_idle();
        run("read0b", '{8'h0B, 8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85}, 1'b1, 1'b1, 1'b0);
        drain_rx();

        // R4: striping state, but separate-bus bit clear -> bus 0 only
        run("stripe1", '{8'h90, 8'h91, 8'h92}, 1'b0, 1'b1, 1'b0);
        drain_rx();

        // R3: receive FIFO fills, extra bytes dropped, run continues
        chip_idle();
        rx_cap = 2;
        run("ovf", '{8'h03, 8'hB1, 8'hB2, 8'hB3, 8'hB4}, 1'b1, 1'b1, 1'b0);
        drain_rx();
        rx_cap = 64;

        // R2: start with an empty FIFO gives only an underflow
        run("empty", '{}, 1'b1, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule